// File: doc/BRIEF.md
# SPI Transmit Staging Controller

This block sits between the bus-side transmit data register of an SPI peripheral and its serial shifter. Words written by software or by a DMA engine are staged here and handed to the shifter through a load strobe. A mode input chooses between two staging schemes. The first is a single holding slot guarded by a "read the status, then write" rule. The second is a small queue that accepts writes freely and reports empty only after every queued word has left.

The block drives a transmit-empty flag for software and a transmit DMA request. When DMA is enabled, the flag is cleared by the DMA completion pulse rather than by the data write. In single-slot mode, when the shifter keeps running and no new word is waiting, the block reloads the word it sent last, so the line repeats that word.

Top module: `spitx_path`

## Requirements
- R1: After reset `tx_empty` is 1, `dma_req` is 0 and `sh_load` is 0.
- R2: In single-slot mode (`fifo_mode`=0) with `dma_en`=0, a write is taken only if, since the last accepted write, a `stat_rd` pulse occurred while `tx_empty` was 1. Any other write is dropped and never reaches the shifter.
- R3: A write accepted while `dma_en`=0 makes `tx_empty` 0 in the cycle after the write, in either mode.
- R4: When the shifter is idle, a word written in cycle k is presented with `sh_load`=1 in cycle k+1, and `tx_empty` reads 1 again in cycle k+2.
- R5: A word queued behind a busy shifter is loaded in the cycle `sh_done` is 1. `tx_empty` becomes 1 in the following cycle when nothing else is waiting.
- R6: In single-slot mode, an `sh_done` with nothing staged raises `sh_load` again with the previously loaded word on `sh_data`, and `tx_empty` stays 1. In queue mode no load is issued when nothing is staged.
- R7: In queue mode (`fifo_mode`=1) writes need no status read. `tx_empty` stays 0 while any accepted word has not yet been loaded, and becomes 1 in the cycle after the last one is loaded.
- R8: The queue holds 4 words and single-slot mode holds 1. A write arriving while the store is full is discarded.
- R9: `dma_req` equals `dma_en` AND `tx_empty` in every cycle.
- R10: With `dma_en`=1, accepted writes leave `tx_empty` unchanged. A `dma_done` pulse makes it 0 in the next cycle, unless the same cycle loads the last staged word.
- R11: `sh_load` is raised only when `sh_busy` is 0 or `sh_done` is 1, and staged words reach the shifter in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 0 = single holding slot, 1 = four-entry queue |
| dma_en | input | 1 | Transmit DMA enabled |
| stat_rd | input | 1 | One-cycle pulse: status register read |
| wr_en | input | 1 | One-cycle pulse: data register write |
| wr_data | input | 16 | Word written to the data register |
| dma_done | input | 1 | One-cycle pulse: transmit DMA transfer completed |
| sh_busy | input | 1 | Shifter is transferring a word |
| sh_done | input | 1 | Last cycle of the shifter's current transfer |
| sh_load | output | 1 | Shifter takes `sh_data` at this clock edge |
| sh_data | output | 16 | Word offered to the shifter |
| tx_empty | output | 1 | Transmit-empty flag |
| dma_req | output | 1 | Transmit DMA request |

## Verification
The embedded properties assume that `fifo_mode` changes only while nothing is staged. They also assume that `sh_done` is raised only while `sh_busy` is 1 and that `dma_en` is stable around writes. The stimulus switches modes only after the flag reads 1 and the shifter model has gone idle. The shifter model pulses done in the last busy cycle and can be frozen busy or told to stop without a done pulse. The single-slot bound also depends on the mode staying put while a word is held, and every mode switch in the bench happens with the store empty.

// File: rtl/spitx_pkg.sv
package spitx_pkg;

  typedef enum logic {
    TXM_SINGLE = 1'b0,
    TXM_QUEUE  = 1'b1
  } txmode_e;

endpackage

// File: rtl/spitx_rstsync.sv
module spitx_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/spitx_store.sv
module spitx_store
  import spitx_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  txmode_e      mode,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         nonempty,
  output logic         last
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  ent [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_d;
      if (pop)  rd_ptr_q <= rd_ptr_d;
      if (push != pop) cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic         sel;
    logic [W-1:0] ent_q;
    assign sel = push && (wr_ptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (sel) begin
        ent_q <= din;
      end
    end
    assign ent[i] = ent_q;
  end

  assign head     = ent[rd_ptr_q];
  assign nonempty = (cnt_q != '0);
  assign last     = (cnt_q == CW'(1));
  assign full     = (mode == TXM_QUEUE) ? (cnt_q == CW'(DEPTH)) : nonempty;

  // R8: occupancy never passes the queue size
  assert_count_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R8: single-slot mode keeps at most one word
  assert_single_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TXM_SINGLE) |-> (cnt_q <= CW'(1)));

  // R11: the feeder never takes a word from an empty store
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/spitx_flag.sv
module spitx_flag
  import spitx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  txmode_e mode,
  input  logic    dma_en,
  input  logic    stat_rd,
  input  logic    push,
  input  logic    pop,
  input  logic    last,
  input  logic    dma_done,
  output logic    empty,
  output logic    armed
);

  logic empty_q, empty_d;
  logic armed_q, armed_d;
  logic drained;
  logic clr;

  always_comb begin
    drained = pop && last && !push;
    clr     = dma_en ? dma_done : push;
    empty_d = empty_q;
    if (drained) begin
      empty_d = 1'b1;
    end else if (clr) begin
      empty_d = 1'b0;
    end
    armed_d = armed_q;
    if (push) begin
      armed_d = 1'b0;
    end else if (stat_rd && empty_q && (mode == TXM_SINGLE)) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (drained || clr) empty_q <= empty_d;
      if (push || stat_rd) armed_q <= armed_d;
    end
  end

  assign empty = empty_q;
  assign armed = armed_q;

  // R3: a write taken without DMA drops the flag next cycle
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !dma_en) |=> !empty_q);

  // R5: moving the final staged word out raises the flag next cycle
  assert_drain_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && last && !push) |=> empty_q);

  // R10: with DMA on, a write alone never lowers the flag
  assert_dma_write_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && push && !dma_done && empty_q) |=> empty_q);

endmodule

// File: rtl/spitx_feed.sv
module spitx_feed
  import spitx_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  txmode_e      mode,
  input  logic         sh_busy,
  input  logic         sh_done,
  input  logic         nonempty,
  input  logic [W-1:0] head,
  output logic         pop,
  output logic         sh_load,
  output logic [W-1:0] sh_data
);

  logic         ready;
  logic         again;
  logic         have_q, have_d;
  logic [W-1:0] last_q, last_d;

  always_comb begin
    ready   = !sh_busy || sh_done;
    pop     = ready && nonempty;
    again   = (mode == TXM_SINGLE) && sh_done && !nonempty && have_q;
    sh_load = pop || again;
    sh_data = pop ? head : last_q;
    last_d  = head;
    have_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (pop) begin
      have_q <= have_d;
      last_q <= last_d;
    end
  end

  // R11: loads only when the shifter can accept one
  assert_load_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |-> (!sh_busy || sh_done));

  // R6: queue mode never repeats a word
  assert_queue_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_load && (mode == TXM_QUEUE)) |-> nonempty);

endmodule

// File: rtl/spitx_path.sv
module spitx_path
  import spitx_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              dma_en,
  input  logic              stat_rd,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              dma_done,
  input  logic              sh_busy,
  input  logic              sh_done,
  output logic              sh_load,
  output logic [WORD_W-1:0] sh_data,
  output logic              tx_empty,
  output logic              dma_req
);

  txmode_e           mode;
  logic              rst_s_n;
  logic              push;
  logic              pop;
  logic              full;
  logic              nonempty;
  logic              last;
  logic              armed;
  logic              empty;
  logic [WORD_W-1:0] head;

  assign mode = txmode_e'(fifo_mode);

  spitx_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign push = wr_en && !full && ((mode == TXM_QUEUE) || dma_en || armed);

  spitx_store #(
    .W     (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode     (mode),
    .push     (push),
    .din      (wr_data),
    .pop      (pop),
    .head     (head),
    .full     (full),
    .nonempty (nonempty),
    .last     (last)
  );

  spitx_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode     (mode),
    .dma_en   (dma_en),
    .stat_rd  (stat_rd),
    .push     (push),
    .pop      (pop),
    .last     (last),
    .dma_done (dma_done),
    .empty    (empty),
    .armed    (armed)
  );

  spitx_feed #(
    .W (WORD_W)
  ) u_feed (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .mode     (mode),
    .sh_busy  (sh_busy),
    .sh_done  (sh_done),
    .nonempty (nonempty),
    .head     (head),
    .pop      (pop),
    .sh_load  (sh_load),
    .sh_data  (sh_data)
  );

  assign tx_empty = empty;
  assign dma_req  = dma_en && empty;

  // R2: an unarmed single-slot write without DMA never lands in the store
  assert_unarmed_dropped_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && (mode == TXM_SINGLE) && !dma_en && !armed && !nonempty) |=> !nonempty || $past(sh_load));

endmodule

// File: tb/sim_spitx_path.sv
module sim_spitx_path;

  localparam int LEN = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fifo_mode, dma_en, stat_rd, wr_en, dma_done;
  logic [15:0] wr_data;
  logic        sh_busy, sh_done;
  logic        sh_load;
  logic [15:0] sh_data;
  logic        tx_empty, dma_req;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] expq[$];
  logic [15:0] last_exp = '0;
  bit          have_last = 0;
  bit          armed_m = 0;
  int          loads = 0;
  int          reps = 0;
  int          cnt = 0;
  bit          stall = 0;
  bit          stop_run = 0;
  bit          load_seen = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  spitx_path u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_mode (fifo_mode),
    .dma_en    (dma_en),
    .stat_rd   (stat_rd),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .dma_done  (dma_done),
    .sh_busy   (sh_busy),
    .sh_done   (sh_done),
    .sh_load   (sh_load),
    .sh_data   (sh_data),
    .tx_empty  (tx_empty),
    .dma_req   (dma_req)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // shifter model plus scoreboard monitor
  always begin
    @(negedge clk);
    if (load_seen) cnt = LEN;
    else if (cnt > 0 && !stall) cnt = cnt - 1;
    load_seen = 0;
    sh_busy = (cnt != 0);
    sh_done = (cnt == 1) && !stall && !stop_run;
    #1;
    if (rst_n && sh_load) begin
      chk(!sh_busy || sh_done, "R11", "load while busy", sh_busy, 0);
      if (expq.size() > 0) begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(sh_data == e, "R11", "load order", sh_data, e);
        last_exp = e;
        have_last = 1;
      end else if (!fifo_mode && have_last) begin
        chk(sh_data == last_exp, "R6", "repeated word", sh_data, last_exp);
        reps++;
      end else begin
        chk(0, "R8", "unexpected load", sh_data, 0);
      end
      load_seen = 1;
      loads++;
    end
  end

  task automatic do_write(input logic [15:0] d);
    bit acc;
    int cap;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    cap = fifo_mode ? 4 : 1;
    acc = (expq.size() < cap) && (fifo_mode || dma_en || armed_m);
    @(posedge clk);
    if (acc) begin
      expq.push_back(d);
      armed_m = 0;
    end
    #1 wr_en = 1'b0;
  endtask

  task automatic do_stat();
    bit e;
    @(negedge clk);
    stat_rd = 1'b1;
    #1 e = tx_empty;
    @(posedge clk);
    if (e && !fifo_mode) armed_m = 1;
    #1 stat_rd = 1'b0;
  endtask

  task automatic do_dma_done();
    @(negedge clk);
    dma_done = 1'b1;
    @(posedge clk);
    #1 dma_done = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_loads(input int target);
    for (int i = 0; i < 200 && loads < target; i++) settle();
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    wrap_up();
  end

  initial begin
    int base;
    int snap;
    bit early;
    rst_n = 1'b0;
    fifo_mode = 1'b0; dma_en = 1'b0; stat_rd = 1'b0; wr_en = 1'b0;
    dma_done = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(tx_empty == 1'b1, "R1", "tx_empty after reset", tx_empty, 1);
    chk(dma_req == 1'b0, "R1", "dma_req after reset", dma_req, 0);
    chk(sh_load == 1'b0, "R1", "sh_load after reset", sh_load, 0);

    // R2: write without status read is dropped
    do_write(16'h1111);
    repeat (3) settle();
    chk(loads == 0, "R2", "unarmed write loaded", loads, 0);
    chk(tx_empty == 1'b1, "R2", "flag after dropped write", tx_empty, 1);

    // R3/R4: armed write, idle shifter
    do_stat();
    do_write(16'h1234);
    settle();
    chk(tx_empty == 1'b0, "R3", "flag after write", tx_empty, 0);
    chk(sh_load == 1'b1, "R4", "load next cycle", sh_load, 1);
    settle();
    chk(tx_empty == 1'b1, "R4", "flag back set", tx_empty, 1);
    stall = 1;

    // R2: arm consumed, R5: queue behind busy shifter
    do_write(16'h5555);
    do_stat();
    do_write(16'hBEEF);
    settle();
    chk(tx_empty == 1'b0, "R5", "flag while queued", tx_empty, 0);
    stall = 0;
    wait_loads(2);
    chk(loads == 2, "R5", "queued word loaded on done", loads, 2);
    settle();
    chk(tx_empty == 1'b1, "R5", "flag after move", tx_empty, 1);

    // R6: single-slot repeat of last word
    repeat (3 * LEN) settle();
    chk(reps >= 2, "R6", "repeat loads seen", reps, 2);
    chk(tx_empty == 1'b1, "R6", "flag during repeats", tx_empty, 1);
    stop_run = 1;
    repeat (2 * LEN + 4) settle();
    snap = loads;
    repeat (2 * LEN) settle();
    chk(loads == snap, "R6", "no load after stop", loads, snap);

    // R7/R8: queue mode
    @(negedge clk);
    fifo_mode = 1'b1;
    stop_run = 0;
    stall = 1;
    base = loads;
    for (int i = 0; i < 6; i++) do_write(16'h0A00 + 16'(i));
    settle();
    chk(tx_empty == 1'b0, "R7", "flag with queue filled", tx_empty, 0);
    chk(dma_req == 1'b0, "R9", "no request without dma", dma_req, 0);
    stall = 0;
    early = 0;
    for (int i = 0; i < 200 && loads < base + 5; i++) begin
      settle();
      if (expq.size() != 0 && tx_empty) early = 1;
    end
    chk(early == 0, "R7", "flag set before drain", early, 0);
    settle();
    chk(tx_empty == 1'b1, "R7", "flag after full drain", tx_empty, 1);
    repeat (4 * LEN) settle();
    chk(loads == base + 5, "R8", "fifth queued write dropped", loads, base + 5);

    // R9/R10: DMA
    @(negedge clk);
    dma_en = 1'b1;
    #2;
    chk(dma_req == 1'b1, "R9", "request when empty", dma_req, 1);
    stall = 1;
    do_write(16'hD000);
    do_write(16'hD001);
    settle();
    chk(tx_empty == 1'b1, "R10", "write keeps flag", tx_empty, 1);
    chk(dma_req == 1'b1, "R9", "request held", dma_req, 1);
    do_dma_done();
    settle();
    chk(tx_empty == 1'b0, "R10", "dma done clears", tx_empty, 0);
    chk(dma_req == 1'b0, "R9", "request drops", dma_req, 0);
    base = loads;
    stall = 0;
    wait_loads(base + 1);
    settle();
    chk(tx_empty == 1'b1, "R5", "flag after dma drain", tx_empty, 1);
    chk(dma_req == 1'b1, "R9", "request returns", dma_req, 1);
    repeat (2 * LEN) settle();
    chk(expq.size() == 0, "R11", "words left undelivered", expq.size(), 0);
    wrap_up();
  end

endmodule